// File: doc/BRIEF.md
# Dual-Granularity Instruction Fetch Buffer

This block sits between a processor's instruction fetch port and the page-register front end of a NAND flash array. It serves 8-byte fetches from two fully associative stores. The first store is the block store. It holds large blocks, each made of SUBS sub-blocks of 8 bytes (512 bytes at the default sizing), so one fill covers a long run of straight-line code. The second store is the reuse store. It holds single 8-byte sub-blocks, so code that is reached again later, for example through a branch, can survive after its large block has gone.

Every entry in the block store keeps one reference flag per sub-block. When a large block is pushed out, only the sub-blocks whose flag is set move into the reuse store. Both stores replace their entries in arrival order. A fetch that misses both stores halts the fetch port until the victim has been scanned and the new block has streamed in from flash.

Top module: `dual_ibuf`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and fill_req are both 0.
- R2: An accepted request that hits the block store gives rsp_valid one cycle later. The response carries the 8-byte sub-block selected by address bits [8:3] and rsp_src = 1. If the sub-block is present in both stores, the block store answers.
- R3: An accepted request that hits only the reuse store gives rsp_valid one cycle later with rsp_src = 2. It raises no fill and changes no state that a later request can observe.
- R4: A request that misses both stores raises fill_req for exactly one cycle. fill_addr carries the block base address, with bits [8:0] at zero. Flash then returns SUBS beats in ascending sub-block order on fill_valid/fill_data. One cycle after the last beat, rsp_valid rises with rsp_src = 0 and the data of the requested sub-block.
- R5: While the block store has a free entry, a miss evicts nothing, and fill_req rises one cycle after the request is accepted.
- R6: When every block-store entry is valid, the oldest-filled entry is the victim. The victim is scanned one sub-block per cycle, so fill_req rises SUBS+1 cycles after acceptance.
- R7: During the victim scan, only sub-blocks whose reference flag is set enter the reuse store, in ascending sub-block order. All other sub-blocks of the victim are dropped, so a later fetch to one of them misses.
- R8: A freshly filled entry has only the flag of the sub-block that caused the miss set. A block-store hit sets the flag of the addressed sub-block.
- R9: The reuse store replaces its entries in arrival order and never takes a sub-block it already holds.
- R10: req_ready stays 0 from the cycle after a missing request is accepted until its response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the fetch; bits [2:0] ignored |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | 64 | The addressed 8-byte sub-block |
| rsp_src | output | 2 | Where the data came from: 0 flash fill, 1 block store, 2 reuse store |
| fill_req | output | 1 | One-cycle request to flash for a block |
| fill_addr | output | ADDR_W | Base byte address of the requested block |
| fill_valid | input | 1 | One beat of fill data present |
| fill_data | input | 64 | Fill beat, one sub-block per beat |

## Verification
A hit in either store must answer exactly one cycle after the accepting edge. On a miss, fill_req is due one cycle after acceptance when a free entry exists, and SUBS+1 cycles after acceptance when a victim has to be scanned. The miss response is due one cycle after the final flash beat. The bench drives inputs and samples outputs on the falling edge and counts falling edges from the accepting edge, so each result is compared in its exact due cycle. A behavioural model made of queues predicts the hit source, whether an eviction happens, and which sub-blocks survive in the reuse store. Data is checked against a pattern computed from the address.

// File: rtl/dual_ibuf_pkg.sv
package dual_ibuf_pkg;

    typedef enum logic [1:0] {
        SRC_FILL = 2'd0,
        SRC_BLK  = 2'd1,
        SRC_REU  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FREQ  = 2'd2,
        ST_FILL  = 2'd3
    } fsm_e;

endpackage

// File: rtl/dual_ibuf_cam.sv
module dual_ibuf_cam #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dual_ibuf.sv
module dual_ibuf
    import dual_ibuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SUBS   = 64,
    parameter int BLK_N  = 4,
    parameter int REU_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic [1:0]        rsp_src,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [63:0]       fill_data
);

    localparam int OFS_W  = 3;
    localparam int SUB_W  = $clog2(SUBS);
    localparam int BTAG_W = ADDR_W - OFS_W - SUB_W;
    localparam int RTAG_W = ADDR_W - OFS_W;
    localparam int BIX_W  = (BLK_N > 1) ? $clog2(BLK_N) : 1;
    localparam int RIX_W  = (REU_N > 1) ? $clog2(REU_N) : 1;

    typedef struct packed {
        fsm_e                                st;
        logic [BLK_N-1:0]                    b_val;
        logic [BLK_N-1:0][BTAG_W-1:0]        b_tag;
        logic [BLK_N-1:0][SUBS-1:0]          b_ref;
        logic [BLK_N-1:0][SUBS-1:0][63:0]    b_dat;
        logic [BIX_W-1:0]                    b_ptr;
        logic [REU_N-1:0]                    r_val;
        logic [REU_N-1:0][RTAG_W-1:0]        r_tag;
        logic [REU_N-1:0][63:0]              r_dat;
        logic [RIX_W-1:0]                    r_ptr;
        logic [ADDR_W-1:0]                   m_addr;
        logic [SUB_W-1:0]                    cnt;
        logic                                o_v;
        logic [63:0]                         o_d;
        src_e                                o_s;
    } ibuf_state_t;

    ibuf_state_t q, d;

    logic [BLK_N-1:0]  b_match;
    logic              b_hit;
    logic [BIX_W-1:0]  b_idx;
    logic [REU_N-1:0]  r_match;
    logic              r_hit;
    logic [RIX_W-1:0]  r_idx;
    logic [RTAG_W-1:0] r_key;
    logic [SUB_W-1:0]  req_sub;
    logic [SUB_W-1:0]  m_sub;
    logic              accept;

    assign req_sub = req_addr[OFS_W +: SUB_W];
    assign m_sub   = q.m_addr[OFS_W +: SUB_W];
    assign r_key   = (q.st == ST_SCAN) ? {q.b_tag[q.b_ptr], q.cnt}
                                       : req_addr[ADDR_W-1:OFS_W];

    dual_ibuf_cam #(.ENTRIES(BLK_N), .TAG_W(BTAG_W)) blk_cam_i (
        .tags (q.b_tag),
        .valid(q.b_val),
        .key  (req_addr[ADDR_W-1:OFS_W+SUB_W]),
        .match(b_match),
        .hit  (b_hit),
        .idx  (b_idx)
    );

    dual_ibuf_cam #(.ENTRIES(REU_N), .TAG_W(RTAG_W)) reu_cam_i (
        .tags (q.r_tag),
        .valid(q.r_val),
        .key  (r_key),
        .match(r_match),
        .hit  (r_hit),
        .idx  (r_idx)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_req  = (q.st == ST_FREQ);
    assign fill_addr = {q.m_addr[ADDR_W-1:OFS_W+SUB_W], {(OFS_W+SUB_W){1'b0}}};
    assign rsp_valid = q.o_v;
    assign rsp_data  = q.o_d;
    assign rsp_src   = q.o_s;

    always_comb begin
        d     = q;
        d.o_v = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (b_hit) begin
                        d.b_ref[b_idx][req_sub] = 1'b1;
                        d.o_v = 1'b1;
                        d.o_d = q.b_dat[b_idx][req_sub];
                        d.o_s = SRC_BLK;
                    end else if (r_hit) begin
                        d.o_v = 1'b1;
                        d.o_d = q.r_dat[r_idx];
                        d.o_s = SRC_REU;
                    end else begin
                        d.m_addr = req_addr;
                        d.cnt    = '0;
                        d.st     = q.b_val[q.b_ptr] ? ST_SCAN : ST_FREQ;
                    end
                end
            end
            ST_SCAN: begin
                if (q.b_ref[q.b_ptr][q.cnt] && !r_hit) begin
                    d.r_val[q.r_ptr] = 1'b1;
                    d.r_tag[q.r_ptr] = {q.b_tag[q.b_ptr], q.cnt};
                    d.r_dat[q.r_ptr] = q.b_dat[q.b_ptr][q.cnt];
                    d.r_ptr = (q.r_ptr == RIX_W'(REU_N-1)) ? '0 : q.r_ptr + 1'b1;
                end
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == SUB_W'(SUBS-1)) begin
                    d.b_val[q.b_ptr] = 1'b0;
                    d.st = ST_FREQ;
                end
            end
            ST_FREQ: begin
                d.cnt = '0;
                d.st  = ST_FILL;
            end
            default: begin
                if (fill_valid) begin
                    d.b_dat[q.b_ptr][q.cnt] = fill_data;
                    if (q.cnt == m_sub) d.o_d = fill_data;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == SUB_W'(SUBS-1)) begin
                        d.b_val[q.b_ptr] = 1'b1;
                        d.b_tag[q.b_ptr] = q.m_addr[ADDR_W-1:OFS_W+SUB_W];
                        d.b_ref[q.b_ptr] = '0;
                        d.b_ref[q.b_ptr][m_sub] = 1'b1;
                        d.b_ptr = (q.b_ptr == BIX_W'(BLK_N-1)) ? '0 : q.b_ptr + 1'b1;
                        d.o_v = 1'b1;
                        d.o_s = SRC_FILL;
                        d.st  = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2 and R3: any accepted hit answers on the next cycle
    p_hit_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (b_hit || r_hit)) |=> rsp_valid);

    p_reu_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !b_hit && r_hit) |=> ($stable(q.b_ref) && $stable(q.r_ptr) && $stable(q.b_val)));

    p_fill_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !q.b_val[q.b_ptr]);

    p_reu_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_match));

    p_blk_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_match));

    p_fill_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req);

endmodule

// File: tb/dual_ibuf_tb_top.sv
module dual_ibuf_tb_top;

    localparam int ADDR_W = 16;
    localparam int SUBS   = 64;
    localparam int BLK_N  = 4;
    localparam int REU_N  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic [1:0]        rsp_src;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_valid;
    logic [63:0]       fill_data;

    int errors = 0;
    int checks = 0;
    int seed   = 7;

    always #4 clk = ~clk;

    dual_ibuf #(.ADDR_W(ADDR_W), .SUBS(SUBS), .BLK_N(BLK_N), .REU_N(REU_N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_src(rsp_src),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [63:0] pat(input int a);
        logic [15:0] w;
        w = 16'(a & ~7);
        return {w, w ^ 16'hffff, 16'(w * 3), w ^ 16'h5a5a};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: queues, oldest at the front
    int          m_btag[$];
    bit [63:0]   m_bref[$];
    int          m_rq[$];

    function automatic bit in_reuse(input int t);
        foreach (m_rq[i]) if (m_rq[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_access(input int a, output int src, output bit ev);
        int bt, sb, rt, hit_i;
        bt = a >> 9; sb = (a >> 3) & 63; rt = a >> 3;
        ev = 1'b0; hit_i = -1;
        foreach (m_btag[i]) if (m_btag[i] == bt) hit_i = i;
        if (hit_i >= 0) begin
            m_bref[hit_i][sb] = 1'b1;
            src = 1;
        end else if (in_reuse(rt)) begin
            src = 2;
        end else begin
            src = 0;
            if (m_btag.size() == BLK_N) begin
                ev = 1'b1;
                for (int k = 0; k < SUBS; k++) begin
                    int t;
                    t = (m_btag[0] << 6) | k;
                    if (m_bref[0][k] && !in_reuse(t)) begin
                        if (m_rq.size() == REU_N) void'(m_rq.pop_front());
                        m_rq.push_back(t);
                    end
                end
                void'(m_btag.pop_front());
                void'(m_bref.pop_front());
            end
            m_btag.push_back(bt);
            m_bref.push_back(64'd1 << sb);
        end
    endtask

    // Flash: answers each block request with SUBS beats
    initial begin
        int nreq;
        nreq = 0;
        fill_valid = 1'b0;
        fill_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && fill_req) begin
                int base;
                base = int'(fill_addr);
                repeat (1 + (nreq % 3)) @(negedge clk);
                nreq++;
                for (int k = 0; k < SUBS; k++) begin
                    fill_valid = 1'b1;
                    fill_data  = pat(base + 8 * k);
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    // Called just after a falling edge with the block idle
    task automatic do_req(input int a, input string tag);
        int exp_src, cyc, fcyc, nfill;
        bit ev, ready_bad, dog;
        string stag;
        model_access(a, exp_src, ev);
        stag = (exp_src == 1) ? "R2" : (exp_src == 2) ? "R3" : "R4";
        check(req_ready === 1'b1, tag, "ready before request (R10)", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; fcyc = -1; nfill = 0; ready_bad = 1'b0; dog = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) ready_bad = 1'b1;
            if (fill_req) begin
                nfill++;
                if (fcyc < 0) fcyc = cyc;
                check(int'(fill_addr) == (a & ~511), "R4", "fill_addr", fill_addr, a & ~511);
            end
            @(negedge clk);
            cyc++;
            if (cyc > 3000) begin dog = 1'b1; break; end
        end
        check(!dog, tag, "watchdog", cyc, 0);
        check(rsp_src == 2'(exp_src), tag, {stag, " source"}, rsp_src, exp_src);
        check(rsp_data == pat(a), tag, {stag, " data"}, rsp_data, pat(a));
        if (exp_src != 0) begin
            check(cyc == 1, tag, {stag, " hit latency"}, cyc, 1);
        end else begin
            check(nfill == 1, "R4", "fill pulses", nfill, 1);
            check(fcyc == (ev ? SUBS + 1 : 1), ev ? "R6" : "R5", "fill_req cycle", fcyc, ev ? SUBS + 1 : 1);
            check(!ready_bad, "R10", "ready low while busy", ready_bad, 0);
        end
    endtask

    initial begin
        int dog;
        dog = 0;
        while (dog < 190000) begin @(negedge clk); dog++; end
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(fill_req === 1'b0, "R1", "fill_req after reset", fill_req, 0);

        do_req(16'h0000, "R5");           // cold miss
        do_req(16'h0000, "R2");           // same sub-block
        do_req(16'h0028, "R8");           // sets flag of sub-block 5
        do_req(16'h01f8, "R4");           // last sub-block, block-store hit
        do_req(16'h0208, "R5");
        do_req(16'h0410, "R5");
        do_req(16'h0618, "R5");
        do_req(16'h0800, "R6");           // evicts block 0
        do_req(16'h0000, "R7");           // promoted -> reuse hit
        do_req(16'h0028, "R7");
        do_req(16'h0000, "R3");           // reuse hit again, nothing moved
        do_req(16'h0030, "R7");           // never referenced -> miss
        do_req(16'h0000, "R2");           // present in both, block store wins
        for (int s = 0; s < 20; s++) do_req(16'h1400 + 8 * s, "R9");
        for (int b = 11; b < 16; b++) do_req(b * 512, "R6");
        for (int s = 0; s < 20; s++) do_req(16'h1400 + 8 * s, "R9");

        for (int n = 0; n < 300; n++) begin
            int blk, sb;
            blk = $urandom(seed + n) % 7;
            sb  = ($urandom(seed * 3 + n) % 6) * 7;
            do_req(blk * 512 + sb * 8, "R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule